// File: doc/BRIEF.md
# Receive Queue with Trigger-Level Flags

This block sits between a serial receiver and a CPU register port. Bytes that the receiver delivers are held in a first-in first-out queue. The CPU reads them out one at a time. The block keeps a live occupancy count for the CPU. It raises a "level reached" flag when the occupancy meets a programmable threshold. It raises a "data waiting" flag when bytes have been sitting below that threshold with no new arrivals for two frame periods.

A byte that arrives while the queue is already full is lost. That loss sets a sticky overrun bit, and the overrun bit blocks all further reception until the CPU writes it back to zero. Both flags follow clear-only-if-false semantics: a CPU write of zero takes effect only when the condition behind the flag has gone away. A queue flush empties the queue and drops both flags. The block drives two level interrupt lines, one for received data and one for errors.

Top module: `rx_trigger_fifo`

## Requirements
- R1: The queue holds 16 bytes and returns them in arrival order. `level` gives the occupancy (0..16) in the cycle after each push or pop. A push and a pop in the same cycle leave `level` unchanged.
- R2: A byte that arrives while `level` is 16, with no read in the same cycle, is discarded and sets `ovr_flag` in the next cycle.
- R3: A byte is accepted only while `rx_on` is 1 and `ovr_flag` is 0. Otherwise `level` and the contents do not change.
- R4: `thr_sel` picks the threshold as follows: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14.
- R5: `lvl_flag` is set in the cycle after a push brings `level` to or above the threshold. It is not set while `level` stays below the threshold.
- R6: On a `frame_tick` cycle, `wait_flag` is set when all of these hold: the queue is non-empty, `level` is below the threshold, and no byte was accepted in this frame or the previous one. A frame is the span of cycles up to and including a tick.
- R7: A `flag_wr` with a 0 in `flag_lvl_wd` clears `lvl_flag` only if `level` after that cycle is below the threshold. A 0 in `flag_wait_wd` clears `wait_flag` only if the queue is then empty. Writing 1 never sets a flag.
- R8: `flush` empties the queue, sets `level` to 0 and clears `lvl_flag` and `wait_flag` in the next cycle. A push in the same cycle is dropped.
- R9: `ovr_flag` is cleared only by `ovr_wr` with `ovr_wd` equal to 0. `err_irq` is high exactly when (`ovr_flag` or `rx_err`) is 1 and (`rxi_on` or `erri_on`) is 1.
- R10: `rx_irq` is high exactly when `rxi_on` is 1 and at least one of `lvl_flag` and `wait_flag` is 1.
- R11: While the queue is empty, `rd_data` is 0 and a read strobe changes nothing.
- R12: After reset the queue is empty, and all flags and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per serial frame period |
| rx_valid | input | 1 | Byte-arrived strobe from the receiver |
| rx_byte | input | 8 | Arriving byte |
| rd_en | input | 1 | CPU read strobe; pops the head byte |
| rx_on | input | 1 | Receive enable |
| rxi_on | input | 1 | Receive interrupt enable |
| erri_on | input | 1 | Receive-error interrupt enable |
| thr_sel | input | 2 | Threshold select |
| flush | input | 1 | Queue flush pulse |
| flag_wr | input | 1 | Status write strobe |
| flag_lvl_wd | input | 1 | Value written to the level flag |
| flag_wait_wd | input | 1 | Value written to the data-waiting flag |
| ovr_wr | input | 1 | Overrun bit write strobe |
| ovr_wd | input | 1 | Value written to the overrun bit |
| rx_err | input | 1 | Receive-error flag from the line checker |
| rd_data | output | 8 | Head byte, 0 when empty |
| level | output | 5 | Occupancy count |
| lvl_flag | output | 1 | Threshold reached flag |
| wait_flag | output | 1 | Data waiting below threshold flag |
| ovr_flag | output | 1 | Sticky overrun bit |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
A pop and an arriving byte can land in the same cycle. A frame tick can also coincide with an arriving byte. For the first case, the bench strobes a read and a byte together, both with a partly filled queue and with a full queue. It checks that `level` holds steady and that the full case raises no overrun. For the second case, it fires a tick in the same cycle as an accepted byte, at a point where two idle frames have already passed. It checks that `wait_flag` stays low while `level` goes up by one.

// File: rtl/rxq_pkg.sv
// Shared helpers for the receive queue: threshold decode.
// Assumes a two-bit select; the table is fixed by the block's behaviour.
package rxq_pkg;
    function automatic int thr_decode(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Byte storage with read/write pointers and an occupancy counter.
// Assumes push and pop are already qualified by the caller (push never
// hits a full queue without a pop, pop never hits an empty queue).
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nx
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;

    // next-occupancy value shared with the flag logic
    always_comb begin
        count_nx = count;
        if (clr)
            count_nx = '0;
        else if (push && !pop)
            count_nx = count + CW'(1);
        else if (pop && !push)
            count_nx = count - CW'(1);
    end

    // pointer and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            count <= count_nx;
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
        end
    end

    // storage write port
    always_ff @(posedge clk) begin
        if (push && !clr) mem[wp] <= din;
    end

    // head byte, zero when empty
    assign dout = (count != '0) ? mem[rp] : '0;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> (count == $past(count) || count == $past(count) + CW'(1)
                         || count + CW'(1) == $past(count))); // R1
endmodule

// File: rtl/rxq_flags.sv
// Level-reached and data-waiting flags with clear-only-if-false writes,
// plus the two-frame idle tracker behind the data-waiting flag.
// Assumes count/count_nx come from the storage module in the same cycle.
module rxq_flags #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic          push,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_nx,
    input  logic [CW-1:0] thr,
    input  logic          wr,
    input  logic          wd_lvl,
    input  logic          wd_wait,
    output logic          lvl_f,
    output logic          wait_f
);
    logic got_cur, got_prev, rcvd_now, idle_hit;

    assign rcvd_now = got_cur || push;
    assign idle_hit = tick && !rcvd_now && !got_prev &&
                      (count != '0) && (count < thr);

    // frame activity tracking: this frame and the one before
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_cur  <= 1'b0;
            got_prev <= 1'b0;
        end else if (tick) begin
            got_cur  <= 1'b0;
            got_prev <= rcvd_now;
        end else if (push) begin
            got_cur  <= 1'b1;
        end
    end

    // level-reached flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            lvl_f <= 1'b0;
        else if (push && count_nx >= thr)
            lvl_f <= 1'b1;
        else if (wr && !wd_lvl && count_nx < thr)
            lvl_f <= 1'b0;
    end

    // data-waiting flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            wait_f <= 1'b0;
        else if (idle_hit)
            wait_f <= 1'b1;
        else if (wr && !wd_wait && count_nx == '0)
            wait_f <= 1'b0;
    end

    AST_WAIT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_f) |-> $past(count) != '0); // R6
    AST_LVL_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_f) |-> count >= thr || $past(thr) != thr); // R5
endmodule

// File: rtl/rxq_err.sv
// Sticky overrun bit and error interrupt line.
// Assumes the set input is a one-cycle loss event from the top.
module rxq_err (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr,
    input  logic wd,
    input  logic line_err,
    input  logic rxi_on,
    input  logic erri_on,
    output logic ovr,
    output logic irq
);
    // overrun bit: set on loss, cleared only by a zero write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr <= 1'b0;
        else if (set)
            ovr <= 1'b1;
        else if (wr && !wd)
            ovr <= 1'b0;
    end

    // error interrupt level
    assign irq = (ovr || line_err) && (rxi_on || erri_on);

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr) |-> $past(wr) && !$past(wd)); // R9
endmodule

// File: rtl/rx_trigger_fifo.sv
// Receive queue top: qualifies pushes and pops, detects loss and ties the
// storage, flag and error pieces together.
// Assumes all inputs are synchronous to clk and strobes last one cycle.
module rx_trigger_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          rd_en,
    input  logic          rx_on,
    input  logic          rxi_on,
    input  logic          erri_on,
    input  logic [1:0]    thr_sel,
    input  logic          flush,
    input  logic          flag_wr,
    input  logic          flag_lvl_wd,
    input  logic          flag_wait_wd,
    input  logic          ovr_wr,
    input  logic          ovr_wd,
    input  logic          rx_err,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] level,
    output logic          lvl_flag,
    output logic          wait_flag,
    output logic          ovr_flag,
    output logic          rx_irq,
    output logic          err_irq
);
    import rxq_pkg::*;

    logic          accept, pop_ok, push_ok, lost;
    logic [CW-1:0] level_nx, thr;

    assign thr     = CW'(thr_decode(thr_sel));
    assign accept  = rx_valid && rx_on && !ovr_flag && !flush;
    assign pop_ok  = rd_en && (level != '0) && !flush;
    assign push_ok = accept && ((level != CW'(DEPTH)) || pop_ok);
    assign lost    = accept && (level == CW'(DEPTH)) && !pop_ok;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
        .clk(clk), .rst_n(rst_n), .clr(flush), .push(push_ok), .pop(pop_ok),
        .din(rx_byte), .dout(rd_data), .count(level), .count_nx(level_nx)
    );

    rxq_flags #(.DEPTH(DEPTH)) flags_i (
        .clk(clk), .rst_n(rst_n), .clr(flush), .tick(frame_tick),
        .push(push_ok), .count(level), .count_nx(level_nx), .thr(thr),
        .wr(flag_wr), .wd_lvl(flag_lvl_wd), .wd_wait(flag_wait_wd),
        .lvl_f(lvl_flag), .wait_f(wait_flag)
    );

    rxq_err err_i (
        .clk(clk), .rst_n(rst_n), .set(lost), .wr(ovr_wr), .wd(ovr_wd),
        .line_err(rx_err), .rxi_on(rxi_on), .erri_on(erri_on),
        .ovr(ovr_flag), .irq(err_irq)
    );

    // receive interrupt level
    assign rx_irq = rxi_on && (lvl_flag || wait_flag);

    AST_FULL_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CW'(DEPTH) && rx_valid && rx_on && !ovr_flag && !rd_en && !flush)
        |=> ovr_flag && level == CW'(DEPTH)); // R2
    AST_OVR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !flush) |=> level <= $past(level)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> level == '0 && !lvl_flag && !wait_flag); // R8
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !rx_valid && !flush) |=> level == '0); // R11
endmodule

// File: tb/rx_trigger_fifo_tb_top.sv
module rx_trigger_fifo_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 0, rx_valid = 0, rd_en = 0, rx_on = 1, rxi_on = 1, erri_on = 1;
    logic [7:0] rx_byte = 0;
    logic [1:0] thr_sel = 2'd3;
    logic flush = 0, flag_wr = 0, flag_lvl_wd = 1, flag_wait_wd = 1;
    logic ovr_wr = 0, ovr_wd = 1, rx_err = 0;
    logic [7:0] rd_data;
    logic [4:0] level;
    logic lvl_flag, wait_flag, ovr_flag, rx_irq, err_irq;

    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_trigger_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rd_en(rd_en), .rx_on(rx_on), .rxi_on(rxi_on),
        .erri_on(erri_on), .thr_sel(thr_sel), .flush(flush), .flag_wr(flag_wr),
        .flag_lvl_wd(flag_lvl_wd), .flag_wait_wd(flag_wait_wd), .ovr_wr(ovr_wr),
        .ovr_wd(ovr_wd), .rx_err(rx_err), .rd_data(rd_data), .level(level),
        .lvl_flag(lvl_flag), .wait_flag(wait_flag), .ovr_flag(ovr_flag),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: inputs already driven, return at the next falling edge
    task automatic cyc();
        @(negedge clk);
        frame_tick = 0; rx_valid = 0; rd_en = 0; flush = 0;
        flag_wr = 0; ovr_wr = 0;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1; rx_byte = b; cyc();
    endtask

    task automatic pop();
        rd_en = 1; cyc();
    endtask

    task automatic tick();
        frame_tick = 1; cyc();
    endtask

    task automatic do_flush();
        flush = 1; cyc();
    endtask

    task automatic t_reset();
        check("R12 level", level, 0);
        check("R12 flags", {lvl_flag, wait_flag, ovr_flag}, 0);
        check("R12 irqs", {rx_irq, err_irq}, 0);
        check("R12 rd_data", rd_data, 0);
    endtask

    task automatic t_order();
        thr_sel = 3; do_flush();
        push(8'hA1); push(8'hB2); push(8'hC3);
        check("R1 level after 3 pushes", level, 3);
        check("R1 head byte", rd_data, 8'hA1);
        pop();
        check("R1 second byte", rd_data, 8'hB2);
        check("R1 level after pop", level, 2);
        rx_valid = 1; rx_byte = 8'hD4; rd_en = 1; cyc();
        check("R1 push+pop keeps level", level, 2);
        check("R1 order after push+pop", rd_data, 8'hC3);
        pop();
        check("R1 last byte", rd_data, 8'hD4);
    endtask

    task automatic t_empty_read();
        do_flush();
        pop();
        check("R11 empty read level", level, 0);
        check("R11 empty read data", rd_data, 0);
        push(8'h5E);
        check("R11 pointers intact", rd_data, 8'h5E);
        check("R11 level one", level, 1);
    endtask

    task automatic t_thresholds();
        for (int s = 0; s < 4; s++) begin
            int t;
            t = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
            thr_sel = 2'(s); do_flush();
            for (int i = 0; i < t - 1; i++) push(8'(i));
            check("R5 below threshold no flag", lvl_flag, 0);
            push(8'hFF);
            check("R4 flag at threshold", lvl_flag, 1);
            check("R10 rx_irq with flag", rx_irq, 1);
        end
    endtask

    task automatic t_clear_sem();
        thr_sel = 1; do_flush();
        for (int i = 0; i < 4; i++) push(8'(i));
        check("R5 level flag set", lvl_flag, 1);
        flag_wr = 1; flag_lvl_wd = 0; flag_wait_wd = 1; cyc();
        check("R7 clear ignored while at threshold", lvl_flag, 1);
        pop();
        flag_wr = 1; flag_lvl_wd = 0; cyc();
        check("R7 clear effective below threshold", lvl_flag, 0);
        check("R10 rx_irq drops", rx_irq, 0);
        flag_wr = 1; flag_lvl_wd = 1; flag_wait_wd = 1; cyc();
        check("R7 write of 1 does not set", {lvl_flag, wait_flag}, 0);
    endtask

    task automatic t_wait();
        thr_sel = 3; rxi_on = 1; do_flush();
        push(8'h11); push(8'h22);
        tick();
        check("R6 no flag in receiving frame", wait_flag, 0);
        tick();
        check("R6 no flag one frame after", wait_flag, 0);
        tick();
        check("R6 flag after two idle frames", wait_flag, 1);
        check("R10 rx_irq with wait flag", rx_irq, 1);
        flag_wr = 1; flag_wait_wd = 0; flag_lvl_wd = 1; cyc();
        check("R7 wait clear ignored with data", wait_flag, 1);
        pop(); pop();
        flag_wr = 1; flag_wait_wd = 0; cyc();
        check("R7 wait clear when empty", wait_flag, 0);
        check("R10 rx_irq off", rx_irq, 0);
        // tick coincident with an accepted byte
        push(8'h33); tick(); tick();
        check("R6 still clear before idle tick", wait_flag, 0);
        rx_valid = 1; rx_byte = 8'h44; frame_tick = 1; cyc();
        check("R6 byte in tick cycle blocks flag", wait_flag, 0);
        check("R6 byte accepted", level, 2);
    endtask

    task automatic t_overrun();
        thr_sel = 3; erri_on = 1; rxi_on = 0; do_flush();
        for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
        check("R1 full level", level, 16);
        rx_valid = 1; rx_byte = 8'h99; rd_en = 1; cyc();
        check("R1 push+pop at full no overrun", ovr_flag, 0);
        check("R1 push+pop at full level", level, 16);
        push(8'h77);
        check("R2 overrun set", ovr_flag, 1);
        check("R2 byte dropped", level, 16);
        check("R9 err_irq", err_irq, 1);
        check("R2 head unchanged", rd_data, 8'h41);
        pop();
        push(8'h78);
        check("R3 blocked while overrun", level, 15);
        ovr_wr = 1; ovr_wd = 1; cyc();
        check("R9 write 1 keeps overrun", ovr_flag, 1);
        ovr_wr = 1; ovr_wd = 0; cyc();
        check("R9 overrun cleared", ovr_flag, 0);
        check("R9 err_irq drops", err_irq, 0);
        rx_err = 1; cyc();
        check("R9 err_irq from line error", err_irq, 1);
        rx_err = 0;
        push(8'h79);
        check("R3 accepted after clear", level, 16);
        pop(); rx_on = 0; push(8'h7A);
        check("R3 rx_on low blocks", level, 15);
        rx_on = 1; rxi_on = 1;
    endtask

    task automatic t_flush();
        thr_sel = 0; do_flush();
        push(8'h01); push(8'h02);
        check("R5 flag before flush", lvl_flag, 1);
        rx_valid = 1; rx_byte = 8'h03; flush = 1; cyc();
        check("R8 level zero", level, 0);
        check("R8 flags clear", {lvl_flag, wait_flag}, 0);
        check("R8 data zero", rd_data, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order();
        t_empty_read();
        t_thresholds();
        t_clear_sem();
        t_wait();
        t_overrun();
        t_flush();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule